// File: doc/BRIEF.md
# Dual-Port Semaphore Token Bank

This block holds a bank of one-bit semaphore tokens that a left port and a right port share. It is used to arbitrate exclusive ownership of a shared resource between two agents. A port asks for a token by writing 0 and gives up a token, or drops a request it has already made, by writing 1. A read tells a port whether it currently holds the addressed token.

A request that finds the token held by the other side is not lost. It stays latched as a waiting request, and the token passes to the waiting side on the same clock edge where the holder lets it go. When both sides ask for a free token in the same cycle, the left side gets it and the right side's request is left waiting. Each port has an active-low semaphore select and an active-low memory chip enable. An access counts as a semaphore access only when the select is low and the chip enable is high. Each port also has a write strobe, a token index, a single write-data bit, and a read bus as wide as the data path. The read bus is combinational from the registered token state.

Top module: `tok_sema_bank`

## Requirements
- R1: After reset every token is free with no waiting request, so both ports read all ones (16'hFFFF) at every index.
- R2: A write takes effect only when the port's semaphore select is low (0), its memory chip enable is high (1) and its write strobe is high (1). Any other combination changes no token.
- R3: A write of 0 to a free token makes the writing port the holder at that clock edge, and in the next cycle that port reads 16'h0000 at that index.
- R4: The read bus always shows the token at the port's current index, with the bit copied onto all 16 lines: 16'h0000 when that port holds it, 16'hFFFF when the other port holds it or nobody does.
- R5: A write of 0 to a token held by the other port leaves the holder unchanged, and the requester keeps reading 16'hFFFF.
- R6: When the holder writes 1 while the other port has a waiting request, the waiting port becomes the holder at that edge and reads 16'h0000 in the next cycle.
- R7: A waiting port that writes 1 withdraws its request, so a later release by the holder leaves the token free for both ports.
- R8: Writes of 0 from both ports to the same free token in the same cycle give it to the left port and leave the right request waiting. The two ports never both read 0 at the same index.
- R9: The eight tokens, selected by the 3-bit index, are independent. An action on one index changes no other index.
- R10: A holder writing 0 again, or a port that neither holds nor waits writing 1, changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| l_sel_n | input | 1 | Left semaphore select, active low |
| l_ram_ce_n | input | 1 | Left memory chip enable, active low; must be high for a token access |
| l_wr | input | 1 | Left write strobe |
| l_idx | input | 3 | Left token index |
| l_wbit | input | 1 | Left write bit (0 request, 1 release or withdraw) |
| l_rdata | output | 16 | Left read bus, token bit copied onto all lines |
| r_sel_n | input | 1 | Right semaphore select, active low |
| r_ram_ce_n | input | 1 | Right memory chip enable, active low; must be high for a token access |
| r_wr | input | 1 | Right write strobe |
| r_idx | input | 3 | Right token index |
| r_wbit | input | 1 | Right write bit |
| r_rdata | output | 16 | Right read bus |

## Verification
Several properties are checked on every cycle. A holder keeps its token unless it releases it, a waiting request takes over on the holder's release, a left request on a free token always wins, a withdrawn request disappears, the read bus is always all-zero or all-one, and the two ports never both read 0 at one index. Some behaviour can only be shown by the bench scenarios, because it depends on a sequence of events. These are the reset state of all eight tokens, writes that are ignored because of the select or chip enable level, an ordered request–withdraw–release sequence ending free, a same-cycle tie followed by handover, and the independence of untouched indices.

// File: rtl/tok_sema_pkg.sv
package tok_sema_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'b00,
    OWN_LEFT  = 2'b01,
    OWN_RIGHT = 2'b10
  } owner_e;
endpackage

// File: rtl/tok_rst_sync.sv
module tok_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_q_n = sync_q[1];
endmodule

// File: rtl/tok_port_dec.sv
module tok_port_dec #(
  parameter int N_SEM = 8,
  localparam int IDX_W = $clog2(N_SEM)
) (
  input  logic             sel_n,
  input  logic             ram_ce_n,
  input  logic             wr,
  input  logic [IDX_W-1:0] idx,
  input  logic             wbit,
  output logic [N_SEM-1:0] req,
  output logic [N_SEM-1:0] rel
);
  logic wr_ok;
  assign wr_ok = !sel_n && ram_ce_n && wr;

  for (genvar k = 0; k < N_SEM; k++) begin : g_dec
    logic hit;
    assign hit    = wr_ok && (idx == IDX_W'(k));
    assign req[k] = hit && !wbit;
    assign rel[k] = hit && wbit;
  end
endmodule

// File: rtl/tok_cell.sv
module tok_cell
  import tok_sema_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic l_req,
  input  logic l_rel,
  input  logic r_req,
  input  logic r_rel,
  output logic held_l,
  output logic held_r,
  output logic wait_l,
  output logic wait_r
);
  owner_e own_q, own_d;
  logic   wl_q, wl_d, wr_q, wr_d;
  logic   upd;
  logic   want_l, want_r, keep_l, keep_r;

  assign upd    = l_req | l_rel | r_req | r_rel;
  assign want_l = (wl_q | l_req) & ~l_rel;
  assign want_r = (wr_q | r_req) & ~r_rel;
  assign keep_l = (own_q == OWN_LEFT)  & ~l_rel;
  assign keep_r = (own_q == OWN_RIGHT) & ~r_rel;

  always_comb begin
    own_d = OWN_NONE;
    wl_d  = 1'b0;
    wr_d  = 1'b0;
    if (keep_l) begin
      own_d = OWN_LEFT;
      wr_d  = want_r;
    end else if (keep_r) begin
      own_d = OWN_RIGHT;
      wl_d  = want_l;
    end else if (want_l) begin
      own_d = OWN_LEFT;
      wr_d  = want_r;
    end else if (want_r) begin
      own_d = OWN_RIGHT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q <= OWN_NONE;
      wl_q  <= 1'b0;
      wr_q  <= 1'b0;
    end else if (upd) begin
      own_q <= own_d;
      wl_q  <= wl_d;
      wr_q  <= wr_d;
    end
  end

  assign held_l = (own_q == OWN_LEFT);
  assign held_r = (own_q == OWN_RIGHT);
  assign wait_l = wl_q;
  assign wait_r = wr_q;
endmodule

// File: rtl/tok_sema_bank.sv
module tok_sema_bank #(
  parameter int N_SEM  = 8,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(N_SEM)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_sel_n,
  input  logic              l_ram_ce_n,
  input  logic              l_wr,
  input  logic [IDX_W-1:0]  l_idx,
  input  logic              l_wbit,
  output logic [DATA_W-1:0] l_rdata,
  input  logic              r_sel_n,
  input  logic              r_ram_ce_n,
  input  logic              r_wr,
  input  logic [IDX_W-1:0]  r_idx,
  input  logic              r_wbit,
  output logic [DATA_W-1:0] r_rdata
);
  logic             rst_q_n;
  logic [N_SEM-1:0] req_l, rel_l, req_r, rel_r;
  logic [N_SEM-1:0] held_l, held_r, wait_l, wait_r;

  tok_rst_sync i_rst (.clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n));

  tok_port_dec #(.N_SEM(N_SEM)) i_dec_l (
    .sel_n(l_sel_n), .ram_ce_n(l_ram_ce_n), .wr(l_wr), .idx(l_idx),
    .wbit(l_wbit), .req(req_l), .rel(rel_l)
  );

  tok_port_dec #(.N_SEM(N_SEM)) i_dec_r (
    .sel_n(r_sel_n), .ram_ce_n(r_ram_ce_n), .wr(r_wr), .idx(r_idx),
    .wbit(r_wbit), .req(req_r), .rel(rel_r)
  );

  for (genvar k = 0; k < N_SEM; k++) begin : g_cell
    tok_cell i_cell (
      .clk(clk), .rst_n(rst_q_n),
      .l_req(req_l[k]), .l_rel(rel_l[k]),
      .r_req(req_r[k]), .r_rel(rel_r[k]),
      .held_l(held_l[k]), .held_r(held_r[k]),
      .wait_l(wait_l[k]), .wait_r(wait_r[k])
    );
  end

  assign l_rdata = {DATA_W{~held_l[l_idx]}};
  assign r_rdata = {DATA_W{~held_r[r_idx]}};
endmodule

// File: rtl/tok_sema_chk.sv
module tok_sema_chk #(
  parameter int N_SEM  = 8,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(N_SEM)
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic [IDX_W-1:0]  l_idx,
  input logic [IDX_W-1:0]  r_idx,
  input logic [DATA_W-1:0] l_rdata,
  input logic [DATA_W-1:0] r_rdata,
  input logic [N_SEM-1:0]  req_l,
  input logic [N_SEM-1:0]  rel_l,
  input logic [N_SEM-1:0]  req_r,
  input logic [N_SEM-1:0]  rel_r,
  input logic [N_SEM-1:0]  held_l,
  input logic [N_SEM-1:0]  held_r,
  input logic [N_SEM-1:0]  wait_r
);
  AST_RD_REPLICATED: assert property (@(posedge clk) disable iff (!rst_q_n)
    (l_rdata == '0 || l_rdata == '1) && (r_rdata == '0 || r_rdata == '1)); // R4
  AST_NEVER_BOTH_ZERO: assert property (@(posedge clk) disable iff (!rst_q_n)
    (l_idx == r_idx) |-> (l_rdata[0] | r_rdata[0])); // R8
  AST_HOLDER_KEEPS_L: assert property (@(posedge clk) disable iff (!rst_q_n)
    ($past(held_l & ~rel_l) & ~held_l) == '0); // R5
  AST_HOLDER_KEEPS_R: assert property (@(posedge clk) disable iff (!rst_q_n)
    ($past(held_r & ~rel_r) & ~held_r) == '0); // R5
  AST_HANDOVER_R: assert property (@(posedge clk) disable iff (!rst_q_n)
    ($past(held_l & rel_l & wait_r & ~rel_r) & ~held_r) == '0); // R6
  AST_LEFT_TIE_WIN: assert property (@(posedge clk) disable iff (!rst_q_n)
    ($past(~held_l & ~held_r & req_l) & ~held_l) == '0); // R8
  AST_WITHDRAW_R: assert property (@(posedge clk) disable iff (!rst_q_n)
    ($past(rel_r) & (wait_r | held_r)) == '0); // R7
  AST_FREE_GRANT_R: assert property (@(posedge clk) disable iff (!rst_q_n)
    ($past(~held_l & ~held_r & req_r & ~req_l) & ~held_r) == '0); // R3
endmodule

bind tok_sema_bank tok_sema_chk #(.N_SEM(N_SEM), .DATA_W(DATA_W)) i_chk (
  .clk(clk), .rst_q_n(rst_q_n), .l_idx(l_idx), .r_idx(r_idx),
  .l_rdata(l_rdata), .r_rdata(r_rdata),
  .req_l(req_l), .rel_l(rel_l), .req_r(req_r), .rel_r(rel_r),
  .held_l(held_l), .held_r(held_r), .wait_r(wait_r)
);

// File: tb/test_tok_sema_bank.sv
module test_tok_sema_bank;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        l_sel_n, l_ram_ce_n, l_wr, l_wbit;
  logic        r_sel_n, r_ram_ce_n, r_wr, r_wbit;
  logic [2:0]  l_idx, r_idx;
  logic [15:0] l_rdata, r_rdata;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  typedef struct {
    bit          right;
    logic [15:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #4 clk = ~clk;

  tok_sema_bank i_tok_sema_bank (
    .clk(clk), .rst_n(rst_n),
    .l_sel_n(l_sel_n), .l_ram_ce_n(l_ram_ce_n), .l_wr(l_wr), .l_idx(l_idx),
    .l_wbit(l_wbit), .l_rdata(l_rdata),
    .r_sel_n(r_sel_n), .r_ram_ce_n(r_ram_ce_n), .r_wr(r_wr), .r_idx(r_idx),
    .r_wbit(r_wbit), .r_rdata(r_rdata)
  );

  task automatic idle();
    l_sel_n = 1'b1; l_ram_ce_n = 1'b1; l_wr = 1'b0; l_wbit = 1'b1; l_idx = '0;
    r_sel_n = 1'b1; r_ram_ce_n = 1'b1; r_wr = 1'b0; r_wbit = 1'b1; r_idx = '0;
  endtask

  task automatic tick();
    @(negedge clk);
    idle();
  endtask

  task automatic set_l(input logic sel_n, input logic ce_n, input logic [2:0] idx,
                       input logic b);
    l_sel_n = sel_n; l_ram_ce_n = ce_n; l_wr = 1'b1; l_idx = idx; l_wbit = b;
  endtask

  task automatic set_r(input logic sel_n, input logic ce_n, input logic [2:0] idx,
                       input logic b);
    r_sel_n = sel_n; r_ram_ce_n = ce_n; r_wr = 1'b1; r_idx = idx; r_wbit = b;
  endtask

  task automatic exp_l(input logic [2:0] idx, input logic [15:0] e, input string tag);
    item_t it;
    l_idx = idx;
    it.right = 1'b0; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic exp_r(input logic [2:0] idx, input logic [15:0] e, input string tag);
    item_t it;
    r_idx = idx;
    it.right = 1'b1; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
  endtask

  // monitor: compares queued expectations one time unit after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb_q.size() > 0) begin
        item_t it;
        logic [15:0] act;
        it  = sb_q.pop_front();
        act = it.right ? r_rdata : l_rdata;
        n_run++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s %s port: got %h expected %h", it.tag,
                   it.right ? "right" : "left", act, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (3000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) tick();

    // R1: all free after reset
    for (int k = 0; k < 8; k++) begin
      exp_l(3'(k), 16'hFFFF, "R1");
      exp_r(3'(k), 16'hFFFF, "R1");
      tick();
    end

    // R2: write with chip enable low, then with select high: ignored
    set_l(1'b0, 1'b0, 3'd1, 1'b0); tick();
    exp_l(3'd1, 16'hFFFF, "R2 ce low"); tick();
    set_l(1'b1, 1'b1, 3'd1, 1'b0); tick();
    exp_l(3'd1, 16'hFFFF, "R2 sel high"); tick();

    // R3: request on free token, R4 other side sees ones
    set_l(1'b0, 1'b1, 3'd1, 1'b0); tick();
    exp_l(3'd1, 16'h0000, "R3");
    exp_r(3'd1, 16'hFFFF, "R4"); tick();

    // R10: holder re-requests, stranger releases: no change
    set_l(1'b0, 1'b1, 3'd1, 1'b0);
    set_r(1'b0, 1'b1, 3'd1, 1'b1); tick();
    exp_l(3'd1, 16'h0000, "R10");
    exp_r(3'd1, 16'hFFFF, "R10"); tick();

    // R5 and R6 on index 2: right holds, left waits, right releases
    set_r(1'b0, 1'b1, 3'd2, 1'b0); tick();
    exp_r(3'd2, 16'h0000, "R3 right"); tick();
    set_l(1'b0, 1'b1, 3'd2, 1'b0); tick();
    exp_l(3'd2, 16'hFFFF, "R5");
    exp_r(3'd2, 16'h0000, "R5"); tick();
    set_r(1'b0, 1'b1, 3'd2, 1'b1); tick();
    exp_l(3'd2, 16'h0000, "R6");
    exp_r(3'd2, 16'hFFFF, "R6"); tick();

    // R7 on index 3: withdrawn request leaves token free after release
    set_l(1'b0, 1'b1, 3'd3, 1'b0); tick();
    set_r(1'b0, 1'b1, 3'd3, 1'b0); tick();
    set_r(1'b0, 1'b1, 3'd3, 1'b1); tick();
    set_l(1'b0, 1'b1, 3'd3, 1'b1); tick();
    exp_l(3'd3, 16'hFFFF, "R7");
    exp_r(3'd3, 16'hFFFF, "R7"); tick();

    // R8 on index 4: tie goes left, right then inherits on release
    set_l(1'b0, 1'b1, 3'd4, 1'b0);
    set_r(1'b0, 1'b1, 3'd4, 1'b0); tick();
    exp_l(3'd4, 16'h0000, "R8 tie");
    exp_r(3'd4, 16'hFFFF, "R8 tie"); tick();
    set_l(1'b0, 1'b1, 3'd4, 1'b1); tick();
    exp_l(3'd4, 16'hFFFF, "R8 handover");
    exp_r(3'd4, 16'h0000, "R8 handover"); tick();

    // R9: untouched indices free, earlier ones unchanged
    for (int k = 5; k < 8; k++) begin
      exp_l(3'(k), 16'hFFFF, "R9");
      exp_r(3'(k), 16'hFFFF, "R9");
      tick();
    end
    exp_l(3'd1, 16'h0000, "R9 keep");
    exp_r(3'd2, 16'hFFFF, "R9 keep"); tick();

    tick();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule